// File: doc/BRIEF.md
# SDRAM Command Spacing and State Monitor

This block watches the command pins of a four-bank SDRAM and flags any command that arrives too early or in the wrong bank state. It decodes each cycle into a command and keeps a small model of every bank: open or closed, whether an auto-precharge is pending, and saturating ages since the bank's last activate, precharge, write and auto-precharge command. Two more ages cover the whole device: one since the last activate to any bank and one since the last mode register set. The block also keeps the burst length from the last mode register set, because the write-recovery and auto-precharge windows depend on it.

Every minimum spacing is given as a picosecond parameter. It is turned into clocks at elaboration, rounding up. When a command breaks a rule, the monitor raises a one-cycle pulse. It also latches the rule code and bank of the first violation until software-independent clear logic (the `clr` pin) drops it. The monitor only observes. It never drives the memory and does not look at the data bus.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With cs_n high the cycle counts as a no-op. With cs_n low, {ras_n,cas_n,we_n} decodes as: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set, 110 burst stop, 111 no-op.
- R2: Each spacing limit is a picosecond parameter, converted to clocks as the ceiling of limit/period. At the default 7500 ps period these give: any-bank activate spacing 2, activate to read/write 3, precharge to activate 3, activate to precharge 6, same-bank activate to activate 9, longest open time 13334.
- R3: Activate timing. An activate fewer than RRD clocks after the previous activate to any bank gives code 7. One fewer than RP clocks after that bank's precharge gives code 8. One fewer than RC clocks after that bank's own previous activate gives code 9.
- R4: A read or write to an open bank fewer than RCD clocks after its activate gives code 6.
- R5: A precharge of an open bank fewer than RAS clocks after its activate gives code 10. Otherwise, a precharge fewer than BL-1+TWR clocks after that bank's last write gives code 11; write data is taken in the write cycle.
- R6: A bank left open without auto-precharge is flagged with code 12 once, in the cycle RASMAX+1 clocks after its activate.
- R7: A mode register set or refresh while any bank is open, including one with an unfinished auto-precharge, gives code 2. Any command other than no-op fewer than TMRD clocks after a mode register set gives code 1.
- R8: A read or write to an open bank with addr[10] high starts auto-precharge. After that, a read or write to the bank gives code 5, and so does an activate, until the bank closes by itself. It closes BL+RP clocks after a read, or BL-1+TWR+RP clocks after a write.
- R9: A read or write to an idle bank gives code 3. An activate to an open bank gives code 4.
- R10: A precharge with addr[10] high closes every open bank. With addr[10] low it closes only the bank on ba.
- R11: err_pulse is high for one cycle, in the cycle after the offending command. When several rules break at once, the lowest code wins, then the lowest bank. err_code and err_bank hold the first violation while err_flag is high. clr drops err_flag. If clr arrives together with a new violation, the new one is recorded. The reported bank is ba for codes 1, 2 and 7, and the bank's own index for every other code. Code 0 means no violation.
- R12: A mode register set loads the burst length from addr[2:0]: 0 gives 1, 1 gives 2, 2 gives 4, any other value gives 8. After reset the burst length is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low to issue a command |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| ba | input | 2 | Bank address |
| addr | input | 11 | Address bus; bit 10 is the all-banks / auto-precharge flag, bits 2:0 the burst length code |
| clr | input | 1 | Drops the sticky violation record |
| err_pulse | output | 1 | Violation seen in the previous cycle |
| err_flag | output | 1 | Sticky violation indicator |
| err_code | output | 4 | Rule code of the recorded violation |
| err_bank | output | 2 | Bank of the recorded violation |

## Verification
The bench sweeps the gap between a command pair across the rule threshold, one clock at a time, for each spacing rule. A design with an off-by-one age counter, or one that truncates instead of rounding up, flags the legal gap or misses the last illegal one. Write recovery and auto-precharge release are swept at burst lengths 1, 4 and 8. A design that ignores the programmed burst length releases a bank too early or too late. Other cases cover rules that hide behind one another (RC behind a premature precharge, write recovery behind the active-time minimum), single versus all-bank precharge, and deselected cycles that look like commands. If the winner selection or the sticky logic is wrong, the wrong code appears or a later fault overwrites the first. The open-time limit is checked cycle by cycle over a window, so an early, late or repeated report is seen.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
  } cmd_e;

  // lower value = higher reporting priority
  typedef enum logic [3:0] {
    V_NONE      = 4'd0,
    V_MRD       = 4'd1,
    V_IDLE_REQ  = 4'd2,
    V_BANK_IDLE = 4'd3,
    V_BANK_OPEN = 4'd4,
    V_AP_BUSY   = 4'd5,
    V_RCD       = 4'd6,
    V_RRD       = 4'd7,
    V_RP        = 4'd8,
    V_RC        = 4'd9,
    V_RAS_MIN   = 4'd10,
    V_WR        = 4'd11,
    V_RAS_MAX   = 4'd12
  } rule_e;

  // ceiling division of a picosecond limit by the clock period
  function automatic int unsigned ps_to_clk(input int unsigned t_ps,
                                            input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic logic [3:0] burst_len(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    if (cs_n) return C_NOP;
    case ({ras_n, cas_n, we_n})
      3'b011:  return C_ACT;
      3'b101:  return C_RD;
      3'b100:  return C_WR;
      3'b010:  return C_PRE;
      3'b001:  return C_REF;
      3'b000:  return C_MRS;
      3'b110:  return C_BST;
      default: return C_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_guard_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_guard_pkg::*;
#(
  parameter int          CW       = 14,
  parameter int unsigned T_RCD    = 3,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RAS    = 6,
  parameter int unsigned T_RASMAX = 13334,
  parameter int unsigned T_RC     = 9,
  parameter int unsigned T_WR     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_e       cmd,
  input  logic       sel,
  input  logic       pre_all,
  input  logic       ap_req,
  input  logic [3:0] bl,
  output logic       open_o,
  output rule_e      code_o
);
  localparam logic [CW-1:0] SMAX = '1;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == SMAX) ? v : v + 1'b1;
  endfunction

  logic          open_q, ap_q;
  logic [CW-1:0] s_act, s_pre, s_wr, s_ap, ap_need;

  // named internal events
  logic          ap_done, ap_live, open_eff, hit_act, hit_rw, hit_pre, ras_late;
  logic [CW-1:0] wr_need, need_rd, need_wr;

  assign ap_done  = ap_q && (s_ap >= ap_need);
  assign ap_live  = ap_q && !ap_done;
  assign open_eff = open_q && !ap_done;
  assign hit_act  = (cmd == C_ACT) && sel;
  assign hit_rw   = ((cmd == C_RD) || (cmd == C_WR)) && sel;
  assign hit_pre  = (cmd == C_PRE) && (sel || pre_all);
  assign ras_late = open_eff && !ap_live && (s_act == CW'(T_RASMAX + 1));
  assign wr_need  = CW'(bl) - 1'b1 + CW'(T_WR);
  assign need_rd  = CW'(bl) + CW'(T_RP);
  assign need_wr  = wr_need + CW'(T_RP);
  assign open_o   = open_eff;

  always_comb begin
    code_o = V_NONE;
    if (hit_act) begin
      if (ap_live)                 code_o = V_AP_BUSY;
      else if (open_eff)           code_o = V_BANK_OPEN;
      else if (s_pre < CW'(T_RP))  code_o = V_RP;
      else if (s_act < CW'(T_RC))  code_o = V_RC;
    end else if (hit_rw) begin
      if (!open_eff)               code_o = V_BANK_IDLE;
      else if (ap_live)            code_o = V_AP_BUSY;
      else if (s_act < CW'(T_RCD)) code_o = V_RCD;
    end else if (hit_pre && open_eff && !ap_live) begin
      if (s_act < CW'(T_RAS))      code_o = V_RAS_MIN;
      else if (s_wr < wr_need)     code_o = V_WR;
    end
    if (code_o == V_NONE && ras_late) code_o = V_RAS_MAX;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      ap_q    <= 1'b0;
      s_act   <= SMAX;
      s_pre   <= SMAX;
      s_wr    <= SMAX;
      s_ap    <= SMAX;
      ap_need <= '0;
    end else begin
      s_act <= bump(s_act);
      s_pre <= bump(s_pre);
      s_wr  <= bump(s_wr);
      s_ap  <= bump(s_ap);
      if (ap_done) begin
        open_q <= 1'b0;
        ap_q   <= 1'b0;
      end
      if (hit_act && !open_eff) begin
        open_q <= 1'b1;
        s_act  <= 1;
      end
      if (hit_rw && open_eff && !ap_live) begin
        if (cmd == C_WR) s_wr <= 1;
        if (ap_req) begin
          ap_q    <= 1'b1;
          s_ap    <= 1;
          ap_need <= (cmd == C_WR) ? need_wr : need_rd;
        end
      end
      if (hit_pre && open_eff && !ap_live) begin
        open_q <= 1'b0;
        s_pre  <= 1;
      end
    end
  end

  // R9: an activate to a closed bank leaves it open with a fresh age
  p_act_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_act && !open_eff |=> open_eff && (s_act == 1));

  // R10: an accepted precharge closes the bank
  p_pre_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pre && open_eff && !ap_live |=> !open_eff);

endmodule

// File: rtl/sdram_err_log.sv
module sdram_err_log
  import sdram_guard_pkg::*;
#(
  parameter int BA_W = 2,
  parameter int NB   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  rule_e           glob_code,
  input  logic [BA_W-1:0] ba,
  input  rule_e           bank_code [NB],
  output logic            pulse_o,
  output logic            flag_o,
  output rule_e           code_o,
  output logic [BA_W-1:0] bank_o
);
  rule_e           best_c;
  logic [BA_W-1:0] best_b;
  logic            hit;

  always_comb begin
    best_c = glob_code;
    best_b = ba;
    for (int i = 0; i < NB; i++) begin
      if (bank_code[i] != V_NONE && (best_c == V_NONE || bank_code[i] < best_c)) begin
        best_c = bank_code[i];
        best_b = BA_W'(i);
      end
    end
  end

  assign hit = (best_c != V_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      flag_o  <= 1'b0;
      code_o  <= V_NONE;
      bank_o  <= '0;
    end else begin
      pulse_o <= hit;
      if (hit && (clr || !flag_o)) begin
        flag_o <= 1'b1;
        code_o <= best_c;
        bank_o <= best_b;
      end else if (clr) begin
        flag_o <= 1'b0;
      end
    end
  end

  // R11: the record is frozen while the flag stands uncleared
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr |=> flag_o && $stable(code_o) && $stable(bank_o));

  // R11: a clear with no fresh fault drops the flag
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !hit |=> !flag_o);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int unsigned CLK_PS     = 7500,
  parameter int unsigned TRRD_PS    = 15000,
  parameter int unsigned TRCD_PS    = 19000,
  parameter int unsigned TRP_PS     = 19000,
  parameter int unsigned TRAS_PS    = 45000,
  parameter int unsigned TRASMAX_PS = 100000000,
  parameter int unsigned TRC_PS     = 64000,
  parameter int unsigned TWR_CLK    = 2,
  parameter int unsigned TMRD_CLK   = 2,
  parameter int          BA_W       = 2,
  parameter int          ADDR_W     = 11,
  parameter int          AP_BIT     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr,
  output logic              err_pulse,
  output logic              err_flag,
  output logic [3:0]        err_code,
  output logic [BA_W-1:0]   err_bank
);
  localparam int unsigned RRD_C    = ps_to_clk(TRRD_PS, CLK_PS);
  localparam int unsigned RCD_C    = ps_to_clk(TRCD_PS, CLK_PS);
  localparam int unsigned RP_C     = ps_to_clk(TRP_PS, CLK_PS);
  localparam int unsigned RAS_C    = ps_to_clk(TRAS_PS, CLK_PS);
  localparam int unsigned RASMAX_C = ps_to_clk(TRASMAX_PS, CLK_PS);
  localparam int unsigned RC_C     = ps_to_clk(TRC_PS, CLK_PS);
  localparam int          NB       = 1 << BA_W;
  localparam int          CW       = $clog2(RASMAX_C + 3);
  localparam logic [CW-1:0] SMAX   = '1;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == SMAX) ? v : v + 1'b1;
  endfunction

  cmd_e            cmd;
  logic [CW-1:0]   since_mrs, since_act_any;
  logic [3:0]      bl_q;
  logic [NB-1:0]   open_v;
  rule_e           bank_code [NB];
  rule_e           glob_code;
  rule_e           code_q;
  logic            is_real, is_mrs, is_act, any_open;

  sdram_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd)
  );

  assign is_real  = (cmd != C_NOP);
  assign is_mrs   = (cmd == C_MRS);
  assign is_act   = (cmd == C_ACT);
  assign any_open = |open_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_mrs     <= SMAX;
      since_act_any <= SMAX;
      bl_q          <= 4'd1;
    end else begin
      since_mrs     <= is_mrs ? CW'(1) : bump(since_mrs);
      since_act_any <= is_act ? CW'(1) : bump(since_act_any);
      if (is_mrs) bl_q <= burst_len(addr[2:0]);
    end
  end

  always_comb begin
    glob_code = V_NONE;
    if (is_real && since_mrs < CW'(TMRD_CLK))
      glob_code = V_MRD;
    else if ((is_mrs || cmd == C_REF) && any_open)
      glob_code = V_IDLE_REQ;
    else if (is_act && since_act_any < CW'(RRD_C))
      glob_code = V_RRD;
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_track #(
      .CW (CW), .T_RCD (RCD_C), .T_RP (RP_C), .T_RAS (RAS_C),
      .T_RASMAX (RASMAX_C), .T_RC (RC_C), .T_WR (TWR_CLK)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .sel     (ba == BA_W'(g)),
      .pre_all (addr[AP_BIT]),
      .ap_req  (addr[AP_BIT]),
      .bl      (bl_q),
      .open_o  (open_v[g]),
      .code_o  (bank_code[g])
    );
  end

  sdram_err_log #(.BA_W (BA_W), .NB (NB)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .glob_code (glob_code),
    .ba        (ba),
    .bank_code (bank_code),
    .pulse_o   (err_pulse),
    .flag_o    (err_flag),
    .code_o    (code_q),
    .bank_o    (err_bank)
  );

  assign err_code = code_q;

  // R7: a command right after a mode register set is reported
  p_mrd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (TMRD_CLK >= 2) && is_mrs ##1 is_real |=> err_pulse);

  // R7: mode set or refresh with a bank open is reported
  p_idle_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs || cmd == C_REF) && any_open |=> err_pulse);

endmodule

// File: tb/sim_sdram_cmd_guard.sv
module sim_sdram_cmd_guard;
  localparam int CK = 7500;

  // requirement codes
  localparam int E_MRD = 1, E_IDLE = 2, E_BIDLE = 3, E_BOPEN = 4, E_AP = 5,
                 E_RCD = 6, E_RRD = 7, E_RP = 8, E_RC = 9, E_RASMIN = 10,
                 E_WR = 11, E_RASMAX = 12;
  localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000,
                         P_BST = 3'b110, P_NOP = 3'b111;
  localparam logic [10:0] A10 = 11'h400;

  function automatic int clocks_for(input int t_ps);
    int n = 0;
    while (n * CK < t_ps) n++;
    return n;
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, clr = 1'b0;
  logic [1:0] ba = '0;
  logic [10:0] addr = '0;
  logic err_pulse, err_flag;
  logic [3:0] err_code;
  logic [1:0] err_bank;
  int checks = 0, fails = 0;
  bit done = 0;

  int t_rrd, t_rcd, t_rp, t_ras, t_rc, t_rasmax;

  always #10 clk = ~clk;

  sdram_cmd_guard #(.TRASMAX_PS (300000)) u0 (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .ba (ba), .addr (addr), .clr (clr),
    .err_pulse (err_pulse), .err_flag (err_flag), .err_code (err_code),
    .err_bank (err_bank)
  );

  task automatic send(input logic [2:0] rcw, input logic [1:0] b,
                      input logic [10:0] ad, input logic cl);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = rcw; ba = b; addr = ad; clr = cl;
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = P_NOP; ba = '0; addr = '0; clr = 1'b0;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) send(P_NOP, 2'd0, 11'd0, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk(input string tag, input logic ep, input int ec, input int eb);
    checks++;
    if (err_pulse !== ep || (ep && (err_code !== ec[3:0] || err_bank !== eb[1:0]))) begin
      fails++;
      $display("FAIL %s: got pulse=%0b code=%0d bank=%0d, expected pulse=%0b code=%0d bank=%0d",
               tag, err_pulse, err_code, err_bank, ep, ec, eb);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int bad;
    t_rrd = clocks_for(15000); t_rcd = clocks_for(19000); t_rp = clocks_for(19000);
    t_ras = clocks_for(45000); t_rc = clocks_for(64000); t_rasmax = clocks_for(300000);
    @(negedge clk);
    do_reset();

    // reset state (R11)
    checks++;
    if (err_pulse !== 1'b0 || err_flag !== 1'b0 || err_code !== 4'd0) begin
      fails++;
      $display("FAIL R11 reset: got pulse=%0b flag=%0b code=%0d, expected 0 0 0",
               err_pulse, err_flag, err_code);
    end

    // R3 / R2: activate spacing across banks
    for (int g = 1; g <= 4; g++) begin
      do_reset(); send(P_ACT, 0, 0, 1); nop(g - 1); send(P_ACT, 1, 0, 1);
      chk($sformatf("R3 rrd g=%0d", g), g < t_rrd, E_RRD, 1);
    end
    // R4: activate to read
    for (int g = 1; g <= 5; g++) begin
      do_reset(); send(P_ACT, 2, 0, 1); nop(g - 1); send(P_RD, 2, 0, 1);
      chk($sformatf("R4 rcd g=%0d", g), g < t_rcd, E_RCD, 2);
    end
    // R3: precharge to activate, same bank
    for (int g = 1; g <= 5; g++) begin
      do_reset(); send(P_ACT, 0, 0, 1); nop(t_ras - 1); send(P_PRE, 0, 0, 1);
      nop(g - 1); send(P_ACT, 0, 0, 1);
      chk($sformatf("R3 rp g=%0d", g), g < t_rp, E_RP, 0);
    end
    // R3: same-bank activate cycle behind an early precharge
    for (int g = 3; g <= 8; g++) begin
      do_reset(); send(P_ACT, 3, 0, 1); nop(1); send(P_PRE, 3, 0, 1);
      nop(g - 1); send(P_ACT, 3, 0, 1);
      chk($sformatf("R3 rc g=%0d", g), (2 + g) < t_rc, E_RC, 3);
    end
    // R5: active time minimum
    for (int g = 1; g <= 8; g++) begin
      do_reset(); send(P_ACT, 1, 0, 1); nop(g - 1); send(P_PRE, 1, 0, 1);
      chk($sformatf("R5 ras g=%0d", g), g < t_ras, E_RASMIN, 1);
    end
    // R5 / R12: write recovery at burst length 4
    for (int g = 1; g <= 7; g++) begin
      do_reset(); send(P_MRS, 0, 11'd2, 1); nop(1);
      send(P_ACT, 0, 0, 1); nop(2); send(P_WR, 0, 0, 1); nop(g - 1);
      send(P_PRE, 0, 0, 1);
      chk($sformatf("R5 wr bl4 g=%0d", g), (3 + g < t_ras) || (g < 4 - 1 + 2),
          (3 + g < t_ras) ? E_RASMIN : E_WR, 0);
    end
    // R12: default burst length 1 and length 8
    for (int g = 1; g <= 3; g++) begin
      do_reset(); send(P_ACT, 0, 0, 1); nop(5); send(P_WR, 0, 0, 1); nop(g - 1);
      send(P_PRE, 0, 0, 1);
      chk($sformatf("R12 wr bl1 g=%0d", g), g < 1 - 1 + 2, E_WR, 0);
    end
    for (int g = 8; g <= 9; g++) begin
      do_reset(); send(P_MRS, 0, 11'd3, 1); nop(1);
      send(P_ACT, 0, 0, 1); nop(5); send(P_WR, 0, 0, 1); nop(g - 1);
      send(P_PRE, 0, 0, 1);
      chk($sformatf("R12 wr bl8 g=%0d", g), g < 8 - 1 + 2, E_WR, 0);
    end
    // R7: mode register spacing, burst stop counts, no-op and deselect do not
    for (int g = 1; g <= 3; g++) begin
      do_reset(); send(P_MRS, 0, 0, 1); nop(g - 1); send(P_ACT, 2, 0, 1);
      chk($sformatf("R7 mrd g=%0d", g), g < 2, E_MRD, 2);
    end
    do_reset(); send(P_MRS, 0, 0, 1); send(P_BST, 1, 0, 1);
    chk("R7 mrd burst stop", 1'b1, E_MRD, 1);
    do_reset(); send(P_MRS, 0, 0, 1); send(P_NOP, 0, 0, 1);
    chk("R1 nop after mrs", 1'b0, 0, 0);
    // R1: deselected activate pattern is ignored
    do_reset(); send(P_MRS, 0, 0, 1);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = P_ACT; clr = 1'b1; @(negedge clk);
    chk("R1 deselect after mrs", 1'b0, 0, 0);
    nop(3); send(P_RD, 0, 0, 1);
    chk("R1 deselect did not open", 1'b1, E_BIDLE, 0);
    // R7: mode set / refresh with a bank open
    do_reset(); send(P_ACT, 1, 0, 1); nop(2); send(P_MRS, 0, 0, 1);
    chk("R7 mrs bank open", 1'b1, E_IDLE, 0);
    do_reset(); send(P_ACT, 3, 0, 1); nop(2); send(P_REF, 2, 0, 1);
    chk("R7 ref bank open", 1'b1, E_IDLE, 2);
    do_reset(); send(P_REF, 0, 0, 1);
    chk("R7 ref all idle", 1'b0, 0, 0);
    // R8: auto-precharge read at BL4
    for (int g = 1; g <= 9; g++) begin
      do_reset(); send(P_MRS, 0, 11'd2, 1); nop(1);
      send(P_ACT, 2, 0, 1); nop(2); send(P_RD, 2, A10, 1); nop(g - 1);
      send(P_ACT, 2, 0, 1);
      chk($sformatf("R8 ap rd g=%0d", g), g < 4 + t_rp, E_AP, 2);
    end
    for (int g = 6; g <= 9; g++) begin
      do_reset(); send(P_MRS, 0, 11'd2, 1); nop(1);
      send(P_ACT, 1, 0, 1); nop(2); send(P_WR, 1, A10, 1); nop(g - 1);
      send(P_ACT, 1, 0, 1);
      chk($sformatf("R8 ap wr g=%0d", g), g < 4 - 1 + 2 + t_rp, E_AP, 1);
    end
    do_reset(); send(P_ACT, 0, 0, 1); nop(2); send(P_RD, 0, A10, 1);
    send(P_WR, 0, 0, 1);
    chk("R8 rw during ap", 1'b1, E_AP, 0);
    // R9: state rules
    do_reset(); send(P_WR, 3, 0, 1);
    chk("R9 write idle bank", 1'b1, E_BIDLE, 3);
    do_reset(); send(P_ACT, 0, 0, 1); nop(4); send(P_ACT, 0, 0, 1);
    chk("R9 activate open bank", 1'b1, E_BOPEN, 0);
    // R11: priority, open bank beats activate spacing
    do_reset(); send(P_ACT, 2, 0, 1); send(P_ACT, 2, 0, 1);
    chk("R11 priority", 1'b1, E_BOPEN, 2);
    // R10: precharge all versus single
    do_reset(); send(P_ACT, 0, 0, 1); nop(1); send(P_ACT, 1, 0, 1); nop(5);
    send(P_PRE, 3, A10, 1);
    chk("R10 pre all legal", 1'b0, 0, 0);
    nop(2); send(P_RD, 0, 0, 1);
    chk("R10 pre all closed b0", 1'b1, E_BIDLE, 0);
    send(P_RD, 1, 0, 1);
    chk("R10 pre all closed b1", 1'b1, E_BIDLE, 1);
    do_reset(); send(P_ACT, 0, 0, 1); nop(1); send(P_ACT, 1, 0, 1); nop(5);
    send(P_PRE, 0, 0, 1); nop(2); send(P_RD, 1, 0, 1);
    chk("R10 single pre kept b1", 1'b0, 0, 0);
    send(P_RD, 0, 0, 1);
    chk("R10 single pre closed b0", 1'b1, E_BIDLE, 0);
    // R6: longest open time, exactly one report
    do_reset(); send(P_ACT, 1, 0, 1);
    bad = 0;
    for (int j = 1; j <= t_rasmax + 5; j++) begin
      send(P_NOP, 0, 0, 1);
      if (err_pulse !== (j == t_rasmax + 1)) bad++;
      if (j == t_rasmax + 1) chk("R6 ras max code", 1'b1, E_RASMAX, 1);
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R6 ras max window: got %0d wrong cycles, expected 0", bad);
    end
    // R11: sticky first record and clear
    do_reset(); send(P_ACT, 0, 0, 1); send(P_RD, 0, 0, 1);
    chk("R11 first", 1'b1, E_RCD, 0);
    send(P_RD, 1, 0, 0);
    checks++;
    if (err_pulse !== 1'b1 || err_flag !== 1'b1 || err_code !== 4'(E_RCD) || err_bank !== 2'd0) begin
      fails++;
      $display("FAIL R11 sticky: got pulse=%0b flag=%0b code=%0d bank=%0d, expected 1 1 %0d 0",
               err_pulse, err_flag, err_code, err_bank, E_RCD);
    end
    send(P_NOP, 0, 0, 1);
    checks++;
    if (err_flag !== 1'b0) begin
      fails++;
      $display("FAIL R11 clear: got flag=%0b, expected 0", err_flag);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule